// File: doc/BRIEF.md
# Dual-Issue Pairing Arbiter

This block sits in the decode stage of an in-order core. On every cycle it examines the two oldest entries of the instruction queue. Each entry arrives already pre-decoded: a kind code, a few addressing and shift attributes, flag usage, one destination register and up to three source registers. The block decides whether to issue the oldest instruction alone or to issue it together with the next one. It then tells the queue how many entries to pop, in the same cycle.

Pairing is allowed only for a small set of ordered combinations. The older instruction always comes first. Register dependencies, any explicit use of the program-counter register and flag conflicts also block a pair. Write resources are bound to slot position. The older instruction always drives write port 0 and the younger one drives write port 1, so no allocation logic is needed. The port groups are registered and present one cycle after the pop.

Top module: `dual_issue_pairer`

## Requirements
- R1: While `rst_n` is low, `pop_cnt` is 0. On the first edge with `rst_n` low, every registered output (`iss_cnt`, `p0_*`, `p1_*`) becomes 0.
- R2: `pop_cnt` is 0 when `q_cnt` is 0. It is 1 when `q_cnt` is 1. It is never above `q_cnt`. A `q_cnt` of 3 is treated as 2. With two entries, `pop_cnt` is 2 exactly when the pair is allowed, and 1 otherwise.
- R3: Kind codes are 0 generic, 1 conditional immediate branch, 2 IT, 3 NOP, 4 load/store-multiple, 5 flag-setting multiply, 6 status-register write, 7 exception-generating, 8 single load, 9 single store, 10 move, 11 data-processing, 12 multiply. Codes 13 to 15 act as generic. A trailing kind 1, 2 or 3 may pair after any leading kind except 4, 5, 6 and 7.
- R4: A leading kind 8 or 9 may pair with a trailing kind 10 or 11 only if all of these hold: the leader has `s0_wb`=0; the leader has either `s0_offreg`=0, or both `s0_shreg`=0 and `s0_shamt` < 4; the trailer has `s1_shreg`=0.
- R5: A leading kind 10 with `s0_shamt`=0 and `s0_shreg`=0 may pair with a trailing kind 10 or 11, whatever shift the trailer uses.
- R6: No other ordering pairs. For example, a data-processing or move leader followed by a single load or store always issues alone, and a multiply never pairs as the trailer.
- R7: A pair is refused when a valid trailing source field equals a valid leading destination. Source field k lies in bits [4k+3:4k] of `sN_src` and is valid when `sN_srcv[k]` is 1. Fields whose valid bit is clear are ignored.
- R8: A pair is refused when both destinations are valid and equal.
- R9: A pair is refused when any valid source or destination field in either slot names register 15.
- R10: A pair is refused when `s0_setf`=1 and `s1_usef`=1.
- R11: One cycle after a pop, port 0 carries the leading slot and port 1 carries the trailing slot if the pop was 2. For a used port, `pN_kind` and `pN_rd` are the slot's kind and destination, and `pN_we` is the slot's destination-valid bit. An unused port reads all zero.
- R12: `iss_cnt` equals the `pop_cnt` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_cnt | input | 2 | Number of valid queue entries offered (0..2) |
| s0_kind | input | 4 | Leading instruction kind code |
| s0_wb | input | 1 | Leading load/store updates its base register |
| s0_offreg | input | 1 | Leading load/store uses a register offset |
| s0_shamt | input | 5 | Leading immediate shift amount |
| s0_shreg | input | 1 | Leading shift amount comes from a register |
| s0_setf | input | 1 | Leading instruction writes the flags |
| s0_dv | input | 1 | Leading destination valid |
| s0_dst | input | 4 | Leading destination register |
| s0_srcv | input | 3 | Leading source field valid bits |
| s0_src | input | 12 | Leading source registers, 4 bits per field |
| s1_kind | input | 4 | Trailing instruction kind code |
| s1_shreg | input | 1 | Trailing shift amount comes from a register |
| s1_usef | input | 1 | Trailing instruction reads the flags |
| s1_dv | input | 1 | Trailing destination valid |
| s1_dst | input | 4 | Trailing destination register |
| s1_srcv | input | 3 | Trailing source field valid bits |
| s1_src | input | 12 | Trailing source registers, 4 bits per field |
| pop_cnt | output | 2 | Entries to pop from the queue this cycle |
| iss_cnt | output | 2 | Registered issue count |
| p0_we | output | 1 | Write port 0 enable |
| p0_rd | output | 4 | Write port 0 register |
| p0_kind | output | 4 | Kind on port group 0 |
| p1_we | output | 1 | Write port 1 enable |
| p1_rd | output | 4 | Write port 1 register |
| p1_kind | output | 4 | Kind on port group 1 |

## Verification
The bench sweeps every pair of leading and trailing kind codes against 32 attribute mixes. This catches a rule table that pairs in reverse order, accepts a base-writeback load, or lets a shift of four slip through. Any of those would show up as a pop of 2 where 1 is expected. Dependency sweeps move a single matching register across each source field and the destination in turn, and also plant matches behind cleared valid bits. A comparator on the wrong field, or one that ignores valid bits, would refuse good pairs or accept bad ones. Register 15 is placed in every field of both slots, flag set/use combinations are tried, and queue occupancies 0 to 3 are applied. Each result is also compared one cycle later on the port groups, where a swapped or mis-timed port mux would show the wrong register.

// File: rtl/dip_pkg.sv
// Shared kind codes and pairing-rule tags for the dual-issue arbiter.
// Assumes a 4-bit pre-decoded kind field; codes 13..15 behave as generic.
package dip_pkg;

    localparam int KIND_W = 4;

    localparam logic [KIND_W-1:0] K_GEN  = 4'd0;
    localparam logic [KIND_W-1:0] K_BRI  = 4'd1;
    localparam logic [KIND_W-1:0] K_ITB  = 4'd2;
    localparam logic [KIND_W-1:0] K_NOP  = 4'd3;
    localparam logic [KIND_W-1:0] K_LSM  = 4'd4;
    localparam logic [KIND_W-1:0] K_MULS = 4'd5;
    localparam logic [KIND_W-1:0] K_PSRW = 4'd6;
    localparam logic [KIND_W-1:0] K_EXC  = 4'd7;
    localparam logic [KIND_W-1:0] K_LD   = 4'd8;
    localparam logic [KIND_W-1:0] K_ST   = 4'd9;
    localparam logic [KIND_W-1:0] K_MOV  = 4'd10;
    localparam logic [KIND_W-1:0] K_ALU  = 4'd11;
    localparam logic [KIND_W-1:0] K_MUL  = 4'd12;

    typedef enum logic [1:0] {
        RULE_NONE = 2'd0,
        RULE_TAIL = 2'd1,
        RULE_MEM  = 2'd2,
        RULE_MOV  = 2'd3
    } pair_rule_e;

    // Trailing kinds that ride along after almost anything.
    function automatic logic is_tail_kind(input logic [KIND_W-1:0] k);
        return (k == K_BRI) || (k == K_ITB) || (k == K_NOP);
    endfunction

    // Leading kinds that must always issue alone.
    function automatic logic is_solo_kind(input logic [KIND_W-1:0] k);
        return (k == K_LSM) || (k == K_MULS) || (k == K_PSRW) || (k == K_EXC);
    endfunction

    // Non-multiply data-processing kinds usable as a trailer.
    function automatic logic is_alu_kind(input logic [KIND_W-1:0] k);
        return (k == K_MOV) || (k == K_ALU);
    endfunction

    // Single memory access kinds.
    function automatic logic is_mem_kind(input logic [KIND_W-1:0] k);
        return (k == K_LD) || (k == K_ST);
    endfunction

endpackage

// File: rtl/dip_class_gate.sv
// Ordered class-pair rule check.
// Decides from kinds and shift/addressing attributes alone whether the
// older slot may lead a pair with the younger slot. Registers are not
// considered here. Only leader-then-trailer orderings are encoded.
module dip_class_gate
    import dip_pkg::*;
#(
    parameter int SHAMT_W   = 5,
    parameter int LSL_LIMIT = 4
) (
    input  logic [KIND_W-1:0]  lead_kind,
    input  logic               lead_wb,
    input  logic               lead_offreg,
    input  logic [SHAMT_W-1:0] lead_shamt,
    input  logic               lead_shreg,
    input  logic [KIND_W-1:0]  trail_kind,
    input  logic               trail_shreg,
    output pair_rule_e         rule
);

    localparam logic [SHAMT_W-1:0] LSL_MAX = SHAMT_W'(LSL_LIMIT);

    logic tail_ok;
    logic mem_lead_ok;
    logic mem_ok;
    logic mov_ok;

    // Evaluate each ordered rule independently.
    always_comb begin
        tail_ok     = !is_solo_kind(lead_kind) && is_tail_kind(trail_kind);
        mem_lead_ok = is_mem_kind(lead_kind) && !lead_wb &&
                      (!lead_offreg || (!lead_shreg && (lead_shamt < LSL_MAX)));
        mem_ok      = mem_lead_ok && is_alu_kind(trail_kind) && !trail_shreg;
        mov_ok      = (lead_kind == K_MOV) && (lead_shamt == '0) && !lead_shreg &&
                      is_alu_kind(trail_kind);
    end

    // Report the first matching rule as a tag.
    always_comb begin
        if (tail_ok)      rule = RULE_TAIL;
        else if (mem_ok)  rule = RULE_MEM;
        else if (mov_ok)  rule = RULE_MOV;
        else              rule = RULE_NONE;
    end

endmodule

// File: rtl/dip_hazard_scan.sv
// Register, program-counter and flag conflict scan between the two slots.
// Every register field is qualified by its own valid bit. Source field k
// sits at bits [k*REG_W +: REG_W].
module dip_hazard_scan #(
    parameter int REG_W  = 4,
    parameter int NSRC   = 3,
    parameter int PC_REG = 15
) (
    input  logic                  lead_dv,
    input  logic [REG_W-1:0]      lead_dst,
    input  logic [NSRC-1:0]       lead_srcv,
    input  logic [NSRC*REG_W-1:0] lead_src,
    input  logic                  lead_setf,
    input  logic                  trail_dv,
    input  logic [REG_W-1:0]      trail_dst,
    input  logic [NSRC-1:0]       trail_srcv,
    input  logic [NSRC*REG_W-1:0] trail_src,
    input  logic                  trail_usef,
    output logic                  raw,
    output logic                  waw,
    output logic                  pc_use,
    output logic                  flag_clash
);

    localparam logic [REG_W-1:0] PC_ID = REG_W'(PC_REG);

    logic [NSRC-1:0] dep_hit;
    logic [NSRC-1:0] lead_pc_hit;
    logic [NSRC-1:0] trail_pc_hit;

    for (genvar k = 0; k < NSRC; k++) begin : g_field
        // Per-field comparators: dependency on leader and r15 use.
        always_comb begin
            dep_hit[k]      = trail_srcv[k] && lead_dv &&
                              (trail_src[k*REG_W +: REG_W] == lead_dst);
            lead_pc_hit[k]  = lead_srcv[k]  && (lead_src[k*REG_W +: REG_W]  == PC_ID);
            trail_pc_hit[k] = trail_srcv[k] && (trail_src[k*REG_W +: REG_W] == PC_ID);
        end
    end

    // Fold per-field hits into the four conflict classes.
    always_comb begin
        raw        = |dep_hit;
        waw        = lead_dv && trail_dv && (lead_dst == trail_dst);
        pc_use     = (|lead_pc_hit) || (|trail_pc_hit) ||
                     (lead_dv && (lead_dst == PC_ID)) ||
                     (trail_dv && (trail_dst == PC_ID));
        flag_clash = lead_setf && trail_usef;
    end

endmodule

// File: rtl/dip_port_stage.sv
// Registered per-port control groups bound statically to slot position.
// Port g is fed only by slot g. It is active when more than g
// instructions issued. Idle ports are zero.
module dip_port_stage #(
    parameter int REG_W  = 4,
    parameter int KIND_W = 4,
    parameter int NPORT  = 2,
    localparam int CNT_W = $clog2(NPORT + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        issue_n,
    input  logic [NPORT-1:0]        slot_dv,
    input  logic [NPORT*REG_W-1:0]  slot_dst,
    input  logic [NPORT*KIND_W-1:0] slot_kind,
    output logic [CNT_W-1:0]        iss_q,
    output logic [NPORT-1:0]        port_we,
    output logic [NPORT*REG_W-1:0]  port_rd,
    output logic [NPORT*KIND_W-1:0] port_kind
);

    // Register the issue count alongside the port groups.
    always_ff @(posedge clk) begin
        if (!rst_n) iss_q <= '0;
        else        iss_q <= issue_n;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        logic used;

        // A port is in use when the issue count reaches past its slot.
        always_comb used = (issue_n > CNT_W'(g));

        // Capture slot g's controls into port group g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                port_we[g]                   <= 1'b0;
                port_rd[g*REG_W +: REG_W]    <= '0;
                port_kind[g*KIND_W +: KIND_W] <= '0;
            end else begin
                port_we[g]                   <= used && slot_dv[g];
                port_rd[g*REG_W +: REG_W]    <= used ? slot_dst[g*REG_W +: REG_W] : '0;
                port_kind[g*KIND_W +: KIND_W] <= used ? slot_kind[g*KIND_W +: KIND_W] : '0;
            end
        end
    end

endmodule

// File: rtl/dual_issue_pairer.sv
// Dual-issue pairing arbiter for a decode stage.
// Combines the ordered class rule with the conflict scan and returns a
// same-cycle pop count to the queue. Registered port groups follow one
// cycle later. Assumes queue entries are offered oldest first and that
// the queue honours pop_cnt at the same clock edge.
module dual_issue_pairer
    import dip_pkg::*;
#(
    parameter int REG_W     = 4,
    parameter int NSRC      = 3,
    parameter int SHAMT_W   = 5,
    parameter int PC_REG    = 15,
    parameter int LSL_LIMIT = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            q_cnt,
    input  logic [KIND_W-1:0]     s0_kind,
    input  logic                  s0_wb,
    input  logic                  s0_offreg,
    input  logic [SHAMT_W-1:0]    s0_shamt,
    input  logic                  s0_shreg,
    input  logic                  s0_setf,
    input  logic                  s0_dv,
    input  logic [REG_W-1:0]      s0_dst,
    input  logic [NSRC-1:0]       s0_srcv,
    input  logic [NSRC*REG_W-1:0] s0_src,
    input  logic [KIND_W-1:0]     s1_kind,
    input  logic                  s1_shreg,
    input  logic                  s1_usef,
    input  logic                  s1_dv,
    input  logic [REG_W-1:0]      s1_dst,
    input  logic [NSRC-1:0]       s1_srcv,
    input  logic [NSRC*REG_W-1:0] s1_src,
    output logic [1:0]            pop_cnt,
    output logic [1:0]            iss_cnt,
    output logic                  p0_we,
    output logic [REG_W-1:0]      p0_rd,
    output logic [KIND_W-1:0]     p0_kind,
    output logic                  p1_we,
    output logic [REG_W-1:0]      p1_rd,
    output logic [KIND_W-1:0]     p1_kind
);

    localparam int NPORT = 2;

    pair_rule_e       rule;
    logic             raw, waw, pc_use, flag_clash;
    logic [1:0]       avail;
    logic             pair_ok;
    logic [NPORT-1:0] port_we;
    logic [NPORT*REG_W-1:0]  port_rd;
    logic [NPORT*KIND_W-1:0] port_kind;

    dip_class_gate #(
        .SHAMT_W   (SHAMT_W),
        .LSL_LIMIT (LSL_LIMIT)
    ) u_gate (
        .lead_kind   (s0_kind),
        .lead_wb     (s0_wb),
        .lead_offreg (s0_offreg),
        .lead_shamt  (s0_shamt),
        .lead_shreg  (s0_shreg),
        .trail_kind  (s1_kind),
        .trail_shreg (s1_shreg),
        .rule        (rule)
    );

    dip_hazard_scan #(
        .REG_W  (REG_W),
        .NSRC   (NSRC),
        .PC_REG (PC_REG)
    ) u_haz (
        .lead_dv    (s0_dv),
        .lead_dst   (s0_dst),
        .lead_srcv  (s0_srcv),
        .lead_src   (s0_src),
        .lead_setf  (s0_setf),
        .trail_dv   (s1_dv),
        .trail_dst  (s1_dst),
        .trail_srcv (s1_srcv),
        .trail_src  (s1_src),
        .trail_usef (s1_usef),
        .raw        (raw),
        .waw        (waw),
        .pc_use     (pc_use),
        .flag_clash (flag_clash)
    );

    // Clamp queue occupancy and hold it at zero during reset.
    always_comb begin
        if (!rst_n)           avail = 2'd0;
        else if (q_cnt > 2'd2) avail = 2'd2;
        else                  avail = q_cnt;
    end

    // Pair only when a rule matched and no conflict was found.
    always_comb pair_ok = (rule != RULE_NONE) && !raw && !waw && !pc_use && !flag_clash;

    // Same-cycle pop count returned to the queue.
    always_comb begin
        if (avail == 2'd0)                 pop_cnt = 2'd0;
        else if (avail == 2'd2 && pair_ok) pop_cnt = 2'd2;
        else                               pop_cnt = 2'd1;
    end

    dip_port_stage #(
        .REG_W  (REG_W),
        .KIND_W (KIND_W),
        .NPORT  (NPORT)
    ) u_ports (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_n   (pop_cnt),
        .slot_dv   ({s1_dv, s0_dv}),
        .slot_dst  ({s1_dst, s0_dst}),
        .slot_kind ({s1_kind, s0_kind}),
        .iss_q     (iss_cnt),
        .port_we   (port_we),
        .port_rd   (port_rd),
        .port_kind (port_kind)
    );

    // Split the packed port groups onto named outputs.
    always_comb begin
        p0_we   = port_we[0];
        p1_we   = port_we[1];
        p0_rd   = port_rd[0 +: REG_W];
        p1_rd   = port_rd[REG_W +: REG_W];
        p0_kind = port_kind[0 +: KIND_W];
        p1_kind = port_kind[KIND_W +: KIND_W];
    end

endmodule

// File: rtl/dual_issue_pairer_chk.sv
// Property checker for the dual-issue arbiter, attached by bind.
// Observes ports only and recomputes conflicts in its own terms.
module dual_issue_pairer_chk
    import dip_pkg::*;
#(
    parameter int REG_W  = 4,
    parameter int NSRC   = 3,
    parameter int PC_REG = 15
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            q_cnt,
    input logic [KIND_W-1:0]     s0_kind,
    input logic                  s0_setf,
    input logic                  s0_dv,
    input logic [REG_W-1:0]      s0_dst,
    input logic [NSRC-1:0]       s0_srcv,
    input logic [NSRC*REG_W-1:0] s0_src,
    input logic [KIND_W-1:0]     s1_kind,
    input logic                  s1_usef,
    input logic                  s1_dv,
    input logic [REG_W-1:0]      s1_dst,
    input logic [NSRC-1:0]       s1_srcv,
    input logic [NSRC*REG_W-1:0] s1_src,
    input logic [1:0]            pop_cnt,
    input logic [1:0]            iss_cnt,
    input logic                  p1_we
);

    logic dep_seen;
    logic pc_seen;

    // Independent scan of fields for dependency and r15 use.
    always_comb begin
        dep_seen = 1'b0;
        pc_seen  = (s0_dv && s0_dst == REG_W'(PC_REG)) || (s1_dv && s1_dst == REG_W'(PC_REG));
        for (int k = 0; k < NSRC; k++) begin
            if (s1_srcv[k] && s0_dv && s1_src[k*REG_W +: REG_W] == s0_dst) dep_seen = 1'b1;
            if (s0_srcv[k] && s0_src[k*REG_W +: REG_W] == REG_W'(PC_REG)) pc_seen = 1'b1;
            if (s1_srcv[k] && s1_src[k*REG_W +: REG_W] == REG_W'(PC_REG)) pc_seen = 1'b1;
        end
    end

    assert_pop_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cnt <= 2'd2) |-> (pop_cnt <= q_cnt));

    assert_no_reverse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_cnt == 2'd2) |-> !(is_alu_kind(s0_kind) && is_mem_kind(s1_kind)));

    assert_no_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_cnt == 2'd2) |-> !dep_seen);

    assert_no_waw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_cnt == 2'd2) |-> !(s0_dv && s1_dv && s0_dst == s1_dst));

    assert_no_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_cnt == 2'd2) |-> !pc_seen);

    assert_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_cnt == 2'd2) |-> !(s0_setf && s1_usef));

    assert_port1_needs_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
        p1_we |-> (iss_cnt == 2'd2));

    assert_issue_follows_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (iss_cnt == $past(pop_cnt)));

endmodule

bind dual_issue_pairer dual_issue_pairer_chk #(
    .REG_W  (REG_W),
    .NSRC   (NSRC),
    .PC_REG (PC_REG)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .q_cnt   (q_cnt),
    .s0_kind (s0_kind),
    .s0_setf (s0_setf),
    .s0_dv   (s0_dv),
    .s0_dst  (s0_dst),
    .s0_srcv (s0_srcv),
    .s0_src  (s0_src),
    .s1_kind (s1_kind),
    .s1_usef (s1_usef),
    .s1_dv   (s1_dv),
    .s1_dst  (s1_dst),
    .s1_srcv (s1_srcv),
    .s1_src  (s1_src),
    .pop_cnt (pop_cnt),
    .iss_cnt (iss_cnt),
    .p1_we   (p1_we)
);

// File: tb/tb_dual_issue_pairer.sv
// Sweep bench for the dual-issue arbiter. The reference model is written
// from the requirement list; pop is checked 2 ns after each falling edge,
// port groups at the following falling edge.
module tb_dual_issue_pairer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  q_cnt;
    logic [3:0]  s0_kind, s1_kind;
    logic        s0_wb, s0_offreg, s0_shreg, s0_setf, s0_dv;
    logic [4:0]  s0_shamt;
    logic [3:0]  s0_dst, s1_dst;
    logic [2:0]  s0_srcv, s1_srcv;
    logic [11:0] s0_src, s1_src;
    logic        s1_shreg, s1_usef, s1_dv;
    logic [1:0]  pop_cnt, iss_cnt;
    logic        p0_we, p1_we;
    logic [3:0]  p0_rd, p1_rd, p0_kind, p1_kind;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    bit  have_prev = 0;
    logic [1:0] e_iss;
    logic       e_p0we, e_p1we;
    logic [3:0] e_p0rd, e_p1rd, e_p0k, e_p1k;

    always #10 clk = ~clk;

    dual_issue_pairer dut (
        .clk(clk), .rst_n(rst_n), .q_cnt(q_cnt),
        .s0_kind(s0_kind), .s0_wb(s0_wb), .s0_offreg(s0_offreg), .s0_shamt(s0_shamt),
        .s0_shreg(s0_shreg), .s0_setf(s0_setf), .s0_dv(s0_dv), .s0_dst(s0_dst),
        .s0_srcv(s0_srcv), .s0_src(s0_src),
        .s1_kind(s1_kind), .s1_shreg(s1_shreg), .s1_usef(s1_usef), .s1_dv(s1_dv),
        .s1_dst(s1_dst), .s1_srcv(s1_srcv), .s1_src(s1_src),
        .pop_cnt(pop_cnt), .iss_cnt(iss_cnt),
        .p0_we(p0_we), .p0_rd(p0_rd), .p0_kind(p0_kind),
        .p1_we(p1_we), .p1_rd(p1_rd), .p1_kind(p1_kind)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model: expected pop count from the requirement text.
    function automatic logic [1:0] model_pop();
        int  n;
        bit  rule_a, rule_b, rule_c, blocked;
        n = (q_cnt > 2) ? 2 : int'(q_cnt);
        if (!rst_n || n == 0) return 2'd0;
        if (n == 1) return 2'd1;
        rule_a = !(s0_kind inside {4'd4, 4'd5, 4'd6, 4'd7}) && (s1_kind inside {4'd1, 4'd2, 4'd3});
        rule_b = (s0_kind inside {4'd8, 4'd9}) && !s0_wb &&
                 (!s0_offreg || (!s0_shreg && s0_shamt < 5'd4)) &&
                 (s1_kind inside {4'd10, 4'd11}) && !s1_shreg;
        rule_c = (s0_kind == 4'd10) && s0_shamt == 5'd0 && !s0_shreg && (s1_kind inside {4'd10, 4'd11});
        blocked = (s0_dv && s1_dv && s0_dst == s1_dst) || (s0_setf && s1_usef) ||
                  (s0_dv && s0_dst == 4'd15) || (s1_dv && s1_dst == 4'd15);
        for (int k = 0; k < 3; k++) begin
            if (s1_srcv[k] && s0_dv && s1_src[4*k +: 4] == s0_dst) blocked = 1;
            if (s0_srcv[k] && s0_src[4*k +: 4] == 4'd15) blocked = 1;
            if (s1_srcv[k] && s1_src[4*k +: 4] == 4'd15) blocked = 1;
        end
        return ((rule_a || rule_b || rule_c) && !blocked) ? 2'd2 : 2'd1;
    endfunction

    task automatic check_ports();
        chk(iss_cnt == e_iss, "R12", "iss_cnt", iss_cnt, e_iss);
        chk(p0_we == e_p0we && p0_rd == e_p0rd && p0_kind == e_p0k, "R11", "port0 {we,rd,kind}",
            {p0_we, p0_rd, p0_kind}, {e_p0we, e_p0rd, e_p0k});
        chk(p1_we == e_p1we && p1_rd == e_p1rd && p1_kind == e_p1k, "R11", "port1 {we,rd,kind}",
            {p1_we, p1_rd, p1_kind}, {e_p1we, e_p1rd, e_p1k});
    endtask

    task automatic begin_cycle();
        @(negedge clk);
        if (have_prev) check_ports();
    endtask

    task automatic end_cycle(input string req);
        logic [1:0] ep;
        #2;
        ep = model_pop();
        chk(pop_cnt == ep, req, "pop_cnt", pop_cnt, ep);
        e_iss  = ep;
        e_p0we = (ep >= 1) && s0_dv;
        e_p0rd = (ep >= 1) ? s0_dst : 4'd0;
        e_p0k  = (ep >= 1) ? s0_kind : 4'd0;
        e_p1we = (ep == 2) && s1_dv;
        e_p1rd = (ep == 2) ? s1_dst : 4'd0;
        e_p1k  = (ep == 2) ? s1_kind : 4'd0;
        have_prev = 1;
    endtask

    task automatic base_pair();
        q_cnt = 2'd2;
        s0_kind = 4'd10; s0_wb = 0; s0_offreg = 0; s0_shamt = 0; s0_shreg = 0; s0_setf = 0;
        s0_dv = 1; s0_dst = 4'd1; s0_srcv = 3'b111; s0_src = {4'd4, 4'd3, 4'd2};
        s1_kind = 4'd11; s1_shreg = 0; s1_usef = 0; s1_dv = 1; s1_dst = 4'd5;
        s1_srcv = 3'b111; s1_src = {4'd8, 4'd7, 4'd6};
    endtask

    function automatic string kind_tag(input int c0, input int c1);
        if (c1 inside {1, 2, 3}) return "R3";
        if (c0 inside {8, 9} && c1 inside {10, 11}) return "R4";
        if (c0 == 10 && c1 inside {10, 11}) return "R5";
        return "R6";
    endfunction

    initial begin
        base_pair();
        // R1: reset holds pop at zero and clears the port groups
        repeat (2) @(negedge clk);
        #2;
        chk(pop_cnt == 2'd0, "R1", "pop_cnt in reset", pop_cnt, 0);
        chk(iss_cnt == 2'd0 && !p0_we && !p1_we && p0_rd == 0 && p1_rd == 0 && p0_kind == 0 && p1_kind == 0,
            "R1", "ports in reset", {iss_cnt, p0_we, p1_we}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 R4 R5 R6: every kind pair across attribute mixes
        for (int c0 = 0; c0 < 16; c0++) begin
            for (int c1 = 0; c1 < 16; c1++) begin
                for (int v = 0; v < 32; v++) begin
                    begin_cycle();
                    base_pair();
                    s0_kind   = 4'(c0);
                    s1_kind   = 4'(c1);
                    s0_wb     = v[0];
                    s0_offreg = v[1];
                    case (v[3:2])
                        2'd0: s0_shamt = 5'd0;
                        2'd1: s0_shamt = 5'd3;
                        2'd2: s0_shamt = 5'd4;
                        default: s0_shamt = 5'd9;
                    endcase
                    s0_shreg  = v[4];
                    s1_shreg  = v[1] ^ v[3];
                    end_cycle(kind_tag(c0, c1));
                end
            end
        end

        // R7 R8: one matching register swept over each trailing field
        for (int d = 0; d < 15; d++) begin
            for (int r = 0; r < 15; r++) begin
                for (int f = 0; f < 4; f++) begin
                    begin_cycle();
                    base_pair();
                    s0_srcv = 3'b000;
                    s0_dst  = 4'(d);
                    s1_srcv = (f < 3) ? 3'(1 << f) : 3'b000;
                    s1_src  = {3{4'(r)}};
                    s1_dv   = (f == 3);
                    s1_dst  = 4'(r);
                    end_cycle((f == 3) ? "R8" : "R7");
                end
            end
            // R7: matching values behind cleared valid bits are ignored
            begin_cycle();
            base_pair();
            s0_dst = 4'(d); s0_srcv = 3'b000;
            s1_srcv = 3'b000; s1_src = {3{4'(d)}}; s1_dv = 0; s1_dst = 4'(d);
            end_cycle("R7");
        end

        // R9: register 15 in each field of each slot, valid and not
        for (int s = 0; s < 2; s++) begin
            for (int f = 0; f < 4; f++) begin
                for (int vb = 0; vb < 2; vb++) begin
                    begin_cycle();
                    base_pair();
                    s0_srcv = 3'b000; s1_srcv = 3'b000;
                    if (s == 0) begin
                        if (f < 3) begin s0_src[4*f +: 4] = 4'd15; s0_srcv = vb[0] ? 3'(1 << f) : 3'b000; end
                        else begin s0_dst = 4'd15; s0_dv = vb[0]; end
                    end else begin
                        if (f < 3) begin s1_src[4*f +: 4] = 4'd15; s1_srcv = vb[0] ? 3'(1 << f) : 3'b000; end
                        else begin s1_dst = 4'd15; s1_dv = vb[0]; end
                    end
                    end_cycle("R9");
                end
            end
        end

        // R10: flag set/use combinations, trailing conditional branch
        for (int fl = 0; fl < 4; fl++) begin
            begin_cycle();
            base_pair();
            s0_kind = 4'd11; s1_kind = 4'd1; s1_dv = 0; s1_srcv = 3'b000;
            s0_setf = fl[0]; s1_usef = fl[1];
            end_cycle("R10");
        end

        // R2: queue occupancy 0..3 with a pairable pair
        for (int q = 0; q < 4; q++) begin
            begin_cycle();
            base_pair();
            q_cnt = 2'(q);
            end_cycle("R2");
        end

        begin_cycle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog actual=%0d expected=%0d", 150000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule